// File: doc/BRIEF.md
# Byte-Range Watchpoint Cache

This block watches memory accesses against a small, fully associative table of address ranges. Each entry covers an inclusive byte range and carries a read-watch bit, a write-watch bit, a bitmap flag with a pointer, and the tag of the hardware thread that owns it. Every access address is compared with all of the current thread's ranges at once. One cycle later the block reports a hit, a miss (a trap that software must handle), or a precise watchpoint fault. When the hit entry carries the bitmap flag, the block reports a bitmap lookup instead.

Software manages the table through a single command port. A SET command installs a new watched range. Every overlapping entry of the current thread gives up the part that the new range covers, and any parts that stay outside it are kept as pieces with their old attributes. One command can therefore turn one entry into three. A FILL command loads a range as given, for example after a miss. An EVICT command removes one entry and presents its contents so that they can be written back to memory. A command that does not fit in the free entries raises an overflow trap and leaves the table as it was.

Top module: `range_watch_cache`

## Requirements
- R1: After reset every entry is invalid. Every access then reports a miss, and no overflow or eviction output is asserted.
- R2: An access presented with `acc_valid` gets its response in the next cycle. It hits an entry when start <= address <= end, with both bounds inclusive, and exactly one of `resp_hit` and `resp_miss` is high. Both are low when no access was presented.
- R3: `cmd_rw` bit 0 is the read-watch bit and bit 1 is the write-watch bit. A hit on an entry without the bitmap flag raises `resp_fault` only when the watch bit for the access direction is set (`acc_write`=1 selects the write bit).
- R4: An access that matches no valid entry of the current thread raises `resp_miss`, with `resp_fault` and `resp_bmp` low.
- R5: A hit on an entry whose bitmap flag is set raises `resp_bmp` and returns its pointer on `resp_ptr`. It never raises `resp_fault`, whatever the entry's watch bits are.
- R6: When several valid entries match, the lowest-index entry supplies `resp_idx` and the result.
- R7: SET (`cmd_op`=00) works on the free pool, which holds the invalid entries and the current thread's entries that overlap the new range. The part of an overlapping entry below the new range and the part above it survive as pieces with their old attributes. The new range goes into the lowest pool slot, the lower piece into the next slot, and the upper piece into the slot after that.
- R8: A SET that needs more slots than the pool holds (one, plus one for each surviving piece) raises `cmd_ovf` for one cycle and changes no entry.
- R9: FILL (`cmd_op`=01) writes the range unchanged into the lowest invalid entry. When no entry is invalid, it raises `cmd_ovf` and changes nothing.
- R10: EVICT (`cmd_op`=10) invalidates entry `cmd_idx`. In the next cycle it presents that entry's start, end, watch bits, flag and pointer, with `ev_valid` equal to the entry's former valid bit.
- R11: Entries are tagged with the thread register (`tid_we`/`tid_wdata`) in force when they are written. Lookups, SET splitting and the SET pool consider only entries of the current thread.
- R12: Adjacent entries with identical attributes are never merged. Each keeps its own index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tid_we | input | 1 | Write the current-thread register |
| tid_wdata | input | $clog2(THREADS) | New current-thread value |
| acc_valid | input | 1 | Access present |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_addr | input | AW | Access byte address |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | 00 SET, 01 FILL, 10 EVICT |
| cmd_start | input | AW | Range start (inclusive) |
| cmd_end | input | AW | Range end (inclusive) |
| cmd_rw | input | 2 | Watch bits: bit 0 read, bit 1 write |
| cmd_bmp | input | 1 | Bitmap flag for the new entry |
| cmd_ptr | input | PTRW | Bitmap pointer for the new entry |
| cmd_idx | input | $clog2(ENTRIES) | Entry index for EVICT |
| resp_hit | output | 1 | Access hit a range |
| resp_miss | output | 1 | Access missed: trap to the handler |
| resp_fault | output | 1 | Precise watchpoint fault |
| resp_idx | output | $clog2(ENTRIES) | Index of the entry that hit |
| resp_bmp | output | 1 | Watch state comes from the bitmap |
| resp_ptr | output | PTRW | Bitmap pointer of the entry that hit |
| cmd_ovf | output | 1 | Overflow trap: the command was not applied |
| ev_valid | output | 1 | Evicted entry was valid |
| ev_start | output | AW | Evicted start |
| ev_end | output | AW | Evicted end |
| ev_rw | output | 2 | Evicted watch bits |
| ev_bmp | output | 1 | Evicted bitmap flag |
| ev_ptr | output | PTRW | Evicted bitmap pointer |

## Verification
The bound properties hold on every cycle. Every access yields exactly one of hit and miss one cycle later. Misses and bitmap hits never fault. An overflow leaves the valid set untouched, and eviction output appears only after an EVICT. Only the directed scenarios can show the actual split geometry: which slot each piece lands in, the inclusive bounds at the piece edges, the priority of the lowest index among overlapping entries, and the isolation between thread tags. Each of these is checked through lookups and evicted contents.

// File: rtl/range_watch_cache.sv
module range_watch_cache #(
  parameter int ENTRIES = 16,
  parameter int AW      = 32,
  parameter int THREADS = 4,
  parameter int PTRW    = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tid_we,
  input  logic [$clog2(THREADS)-1:0]   tid_wdata,
  input  logic                         acc_valid,
  input  logic                         acc_write,
  input  logic [AW-1:0]                acc_addr,
  input  logic                         cmd_valid,
  input  logic [1:0]                   cmd_op,
  input  logic [AW-1:0]                cmd_start,
  input  logic [AW-1:0]                cmd_end,
  input  logic [1:0]                   cmd_rw,
  input  logic                         cmd_bmp,
  input  logic [PTRW-1:0]              cmd_ptr,
  input  logic [$clog2(ENTRIES)-1:0]   cmd_idx,
  output logic                         resp_hit,
  output logic                         resp_miss,
  output logic                         resp_fault,
  output logic [$clog2(ENTRIES)-1:0]   resp_idx,
  output logic                         resp_bmp,
  output logic [PTRW-1:0]              resp_ptr,
  output logic                         cmd_ovf,
  output logic                         ev_valid,
  output logic [AW-1:0]                ev_start,
  output logic [AW-1:0]                ev_end,
  output logic [1:0]                   ev_rw,
  output logic                         ev_bmp,
  output logic [PTRW-1:0]              ev_ptr
);
  localparam int IW = $clog2(ENTRIES);
  localparam int TW = $clog2(THREADS);
  localparam logic [1:0] OP_SET = 2'b00, OP_FILL = 2'b01, OP_EVICT = 2'b10;

  logic [AW-1:0]   st [ENTRIES];
  logic [AW-1:0]   en [ENTRIES];
  logic [1:0]      rw [ENTRIES];
  logic [PTRW-1:0] pt [ENTRIES];
  logic [TW-1:0]   tg [ENTRIES];
  logic [ENTRIES-1:0] vld, bm;
  logic [TW-1:0]   cur_tid;

  logic [ENTRIES-1:0] mine, ovl, lft, rgt, pool;
  logic          hit_any;
  logic [IW-1:0] hit_i, l_i, r_i, s0, s1, s2;
  logic          any_l, any_r, fits;
  int            need, cnt;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      mine[i] = vld[i] && (tg[i] == cur_tid);
      ovl[i]  = mine[i] && (st[i] <= cmd_end) && (en[i] >= cmd_start);
      lft[i]  = ovl[i] && (st[i] < cmd_start);
      rgt[i]  = ovl[i] && (en[i] > cmd_end);
    end
  end

  assign any_l = |lft;
  assign any_r = |rgt;
  assign pool  = (cmd_op == OP_SET) ? (~vld | ovl) : ~vld;
  assign need  = (cmd_op == OP_SET) ? 1 + int'(any_l) + int'(any_r) : 1;
  assign fits  = cnt >= need;

  always_comb begin
    hit_any = 1'b0;
    hit_i   = '0;
    l_i     = '0;
    r_i     = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (mine[i] && st[i] <= acc_addr && en[i] >= acc_addr) begin
        hit_any = 1'b1;
        hit_i   = IW'(i);
      end
      if (lft[i]) l_i = IW'(i);
      if (rgt[i]) r_i = IW'(i);
    end
  end

  always_comb begin
    cnt = 0;
    s0  = '0;
    s1  = '0;
    s2  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (pool[i]) begin
        if (cnt == 0) s0 = IW'(i);
        else if (cnt == 1) s1 = IW'(i);
        else if (cnt == 2) s2 = IW'(i);
        cnt = cnt + 1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld        <= '0;
      cur_tid    <= '0;
      resp_hit   <= 1'b0;
      resp_miss  <= 1'b0;
      resp_fault <= 1'b0;
      resp_idx   <= '0;
      resp_bmp   <= 1'b0;
      resp_ptr   <= '0;
      cmd_ovf    <= 1'b0;
      ev_valid   <= 1'b0;
      ev_start   <= '0;
      ev_end     <= '0;
      ev_rw      <= '0;
      ev_bmp     <= 1'b0;
      ev_ptr     <= '0;
    end else begin
      if (tid_we) cur_tid <= tid_wdata;

      resp_hit   <= acc_valid && hit_any;
      resp_miss  <= acc_valid && !hit_any;
      resp_idx   <= hit_i;
      resp_bmp   <= acc_valid && hit_any && bm[hit_i];
      resp_ptr   <= pt[hit_i];
      resp_fault <= acc_valid && hit_any && !bm[hit_i] &&
                    (acc_write ? rw[hit_i][1] : rw[hit_i][0]);

      cmd_ovf  <= 1'b0;
      ev_valid <= 1'b0;

      if (cmd_valid) begin
        case (cmd_op)
          OP_SET: begin
            if (fits) begin
              for (int i = 0; i < ENTRIES; i++)
                if (ovl[i]) vld[i] <= 1'b0;
              vld[s0] <= 1'b1;
              st[s0]  <= cmd_start;
              en[s0]  <= cmd_end;
              rw[s0]  <= cmd_rw;
              bm[s0]  <= cmd_bmp;
              pt[s0]  <= cmd_ptr;
              tg[s0]  <= cur_tid;
              if (any_l) begin
                vld[s1] <= 1'b1;
                st[s1]  <= st[l_i];
                en[s1]  <= cmd_start - AW'(1);
                rw[s1]  <= rw[l_i];
                bm[s1]  <= bm[l_i];
                pt[s1]  <= pt[l_i];
                tg[s1]  <= cur_tid;
              end
              if (any_r) begin
                vld[any_l ? s2 : s1] <= 1'b1;
                st[any_l ? s2 : s1]  <= cmd_end + AW'(1);
                en[any_l ? s2 : s1]  <= en[r_i];
                rw[any_l ? s2 : s1]  <= rw[r_i];
                bm[any_l ? s2 : s1]  <= bm[r_i];
                pt[any_l ? s2 : s1]  <= pt[r_i];
                tg[any_l ? s2 : s1]  <= cur_tid;
              end
            end else begin
              cmd_ovf <= 1'b1;
            end
          end
          OP_FILL: begin
            if (fits) begin
              vld[s0] <= 1'b1;
              st[s0]  <= cmd_start;
              en[s0]  <= cmd_end;
              rw[s0]  <= cmd_rw;
              bm[s0]  <= cmd_bmp;
              pt[s0]  <= cmd_ptr;
              tg[s0]  <= cur_tid;
            end else begin
              cmd_ovf <= 1'b1;
            end
          end
          OP_EVICT: begin
            ev_valid     <= vld[cmd_idx];
            ev_start     <= st[cmd_idx];
            ev_end       <= en[cmd_idx];
            ev_rw        <= rw[cmd_idx];
            ev_bmp       <= bm[cmd_idx];
            ev_ptr       <= pt[cmd_idx];
            vld[cmd_idx] <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/range_watch_cache_props.sv
module range_watch_cache_props #(
  parameter int ENTRIES = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               acc_valid,
  input logic               cmd_valid,
  input logic [1:0]         cmd_op,
  input logic               resp_hit,
  input logic               resp_miss,
  input logic               resp_fault,
  input logic               resp_bmp,
  input logic               cmd_ovf,
  input logic               ev_valid,
  input logic [ENTRIES-1:0] vld
);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (!resp_hit && !resp_fault && !cmd_ovf && !ev_valid));

  assert_one_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc_valid) |-> (resp_hit != resp_miss));

  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(acc_valid) |-> (!resp_hit && !resp_miss));

  assert_miss_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    resp_miss |-> (!resp_fault && !resp_bmp));

  assert_bitmap_no_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
    resp_bmp |-> (resp_hit && !resp_fault));

  assert_no_overflow_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ovf |-> $stable(vld));

  assert_overflow_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ovf |-> $past(cmd_valid && cmd_op != 2'b10));

  assert_evict_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> $past(cmd_valid && cmd_op == 2'b10));
endmodule

bind range_watch_cache range_watch_cache_props #(.ENTRIES(ENTRIES)) u_props (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_valid  (acc_valid),
  .cmd_valid  (cmd_valid),
  .cmd_op     (cmd_op),
  .resp_hit   (resp_hit),
  .resp_miss  (resp_miss),
  .resp_fault (resp_fault),
  .resp_bmp   (resp_bmp),
  .cmd_ovf    (cmd_ovf),
  .ev_valid   (ev_valid),
  .vld        (vld)
);

// File: tb/range_watch_cache_test.sv
module range_watch_cache_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;
  localparam logic [1:0] SET = 2'b00, FILL = 2'b01, EVICT = 2'b10;
  localparam logic [31:0] TOP = 32'hFFFF_FFFF;

  logic clk = 0, rst_n = 0;
  logic tid_we = 0; logic [1:0] tid_wdata = 0;
  logic acc_valid = 0, acc_write = 0; logic [31:0] acc_addr = 0;
  logic cmd_valid = 0; logic [1:0] cmd_op = 2'b11;
  logic [31:0] cmd_start = 0, cmd_end = 0; logic [1:0] cmd_rw = 0;
  logic cmd_bmp = 0; logic [15:0] cmd_ptr = 0; logic [3:0] cmd_idx = 0;
  logic resp_hit, resp_miss, resp_fault, resp_bmp, cmd_ovf, ev_valid, ev_bmp;
  logic [3:0] resp_idx; logic [15:0] resp_ptr, ev_ptr;
  logic [31:0] ev_start, ev_end; logic [1:0] ev_rw;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  range_watch_cache uut (
    .clk(clk), .rst_n(rst_n), .tid_we(tid_we), .tid_wdata(tid_wdata),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_start(cmd_start), .cmd_end(cmd_end),
    .cmd_rw(cmd_rw), .cmd_bmp(cmd_bmp), .cmd_ptr(cmd_ptr), .cmd_idx(cmd_idx),
    .resp_hit(resp_hit), .resp_miss(resp_miss), .resp_fault(resp_fault),
    .resp_idx(resp_idx), .resp_bmp(resp_bmp), .resp_ptr(resp_ptr), .cmd_ovf(cmd_ovf),
    .ev_valid(ev_valid), .ev_start(ev_start), .ev_end(ev_end), .ev_rw(ev_rw),
    .ev_bmp(ev_bmp), .ev_ptr(ev_ptr));

  task automatic chk(input logic ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic set_tid(input logic [1:0] t);
    @(negedge clk); tid_we = 1; tid_wdata = t;
    @(negedge clk); tid_we = 0;
  endtask

  task automatic cmd(input logic [1:0] op, input logic [31:0] s, input logic [31:0] e,
                     input logic [1:0] w, input logic b, input logic [15:0] p,
                     input logic [3:0] ix, input logic exp_ovf, input string rq);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_start = s; cmd_end = e;
    cmd_rw = w; cmd_bmp = b; cmd_ptr = p; cmd_idx = ix;
    @(negedge clk);
    cmd_valid = 0; cmd_op = 2'b11;
    chk(cmd_ovf == exp_ovf, rq, "cmd_ovf", 64'(cmd_ovf), 64'(exp_ovf));
  endtask

  task automatic look(input logic [31:0] a, input logic wr, input logic eh,
                      input int ei, input logic ef, input logic eb,
                      input logic [15:0] ep, input string rq);
    @(negedge clk);
    acc_valid = 1; acc_addr = a; acc_write = wr;
    @(negedge clk);
    acc_valid = 0;
    chk(resp_hit == eh && resp_miss == !eh, rq, $sformatf("hit@%0h", a),
        64'({resp_hit, resp_miss}), 64'({eh, !eh}));
    if (eh) chk(int'(resp_idx) == ei, rq, $sformatf("idx@%0h", a),
                64'(resp_idx), 64'(ei));
    chk(resp_fault == ef, rq, $sformatf("fault@%0h", a), 64'(resp_fault), 64'(ef));
    chk(resp_bmp == eb, rq, $sformatf("bmp@%0h", a), 64'(resp_bmp), 64'(eb));
    if (eb) chk(resp_ptr == ep, rq, "ptr", 64'(resp_ptr), 64'(ep));
  endtask

  task automatic evict(input int ix, input logic ev, input logic [31:0] s,
                       input logic [31:0] e, input logic [1:0] w, input string rq);
    cmd(EVICT, 0, 0, 0, 0, 0, 4'(ix), 1'b0, rq);
    chk(ev_valid == ev, rq, "ev_valid", 64'(ev_valid), 64'(ev));
    if (ev) chk(ev_start == s && ev_end == e && ev_rw == w, rq, "ev_fields",
                {ev_start, ev_end}, {s, e});
  endtask

  task automatic clear_all();
    for (int i = 0; i < N; i++) begin
      @(negedge clk); cmd_valid = 1; cmd_op = EVICT; cmd_idx = 4'(i);
      @(negedge clk); cmd_valid = 0; cmd_op = 2'b11;
    end
  endtask

  task automatic t_reset();
    look(32'h0, 0, 0, 0, 0, 0, 0, "R1");
    look(TOP, 1, 0, 0, 0, 0, 0, "R1");
    chk(!cmd_ovf && !ev_valid, "R1", "idle outputs", 64'({cmd_ovf, ev_valid}), 0);
  endtask

  task automatic t_split();
    set_tid(0);
    cmd(FILL, 0, TOP, 2'b00, 0, 0, 0, 0, "R9");
    look(32'h400, 0, 1, 0, 0, 0, 0, "R2");
    cmd(SET, 32'h5, 32'h2000, 2'b01, 0, 0, 0, 0, "R7");
    look(32'h400, 0, 1, 0, 1, 0, 0, "R3");
    look(32'h400, 1, 1, 0, 0, 0, 0, "R3");
    look(32'h5, 0, 1, 0, 1, 0, 0, "R2");
    look(32'h2000, 0, 1, 0, 1, 0, 0, "R2");
    look(32'h4, 0, 1, 1, 0, 0, 0, "R7");
    look(32'h0, 0, 1, 1, 0, 0, 0, "R7");
    look(32'h2001, 0, 1, 2, 0, 0, 0, "R7");
    look(TOP, 0, 1, 2, 0, 0, 0, "R7");
    cmd(SET, 32'h2001, 32'h2001, 2'b01, 0, 0, 0, 0, "R7");
    look(32'h2001, 0, 1, 2, 1, 0, 0, "R12");
    look(32'h2000, 0, 1, 0, 1, 0, 0, "R12");
    look(32'h2002, 0, 1, 3, 0, 0, 0, "R7");
    evict(1, 1, 32'h0, 32'h4, 2'b00, "R10");
    look(32'h4, 0, 0, 0, 0, 0, 0, "R10");
    evict(1, 0, 0, 0, 0, "R10");
    clear_all();
  endtask

  task automatic t_multi();
    cmd(FILL, 32'h100, 32'h1FF, 2'b01, 0, 0, 0, 0, "R9");
    cmd(FILL, 32'h200, 32'h3FF, 2'b01, 0, 0, 0, 0, "R9");
    cmd(SET, 32'h180, 32'h2FF, 2'b10, 0, 0, 0, 0, "R7");
    look(32'h17F, 0, 1, 1, 1, 0, 0, "R7");
    look(32'h180, 1, 1, 0, 1, 0, 0, "R7");
    look(32'h180, 0, 1, 0, 0, 0, 0, "R3");
    look(32'h2FF, 1, 1, 0, 1, 0, 0, "R7");
    look(32'h300, 0, 1, 2, 1, 0, 0, "R7");
    look(32'h400, 0, 0, 0, 0, 0, 0, "R4");
    evict(2, 1, 32'h300, 32'h3FF, 2'b01, "R7");
    clear_all();
  endtask

  task automatic t_prio();
    cmd(FILL, 32'h0, 32'hFF, 2'b00, 0, 0, 0, 0, "R6");
    cmd(FILL, 32'h80, 32'h180, 2'b01, 0, 0, 0, 0, "R6");
    look(32'h90, 0, 1, 0, 0, 0, 0, "R6");
    look(32'h150, 0, 1, 1, 1, 0, 0, "R6");
    clear_all();
  endtask

  task automatic t_bitmap();
    cmd(FILL, 32'h1000, 32'h1FFF, 2'b11, 1, 16'h1A2B, 0, 0, "R5");
    look(32'h1800, 1, 1, 0, 0, 1, 16'h1A2B, "R5");
    look(32'h1000, 0, 1, 0, 0, 1, 16'h1A2B, "R5");
    clear_all();
  endtask

  task automatic t_thread();
    set_tid(1);
    cmd(FILL, 32'h0, 32'hFFF, 2'b01, 0, 0, 0, 0, "R11");
    set_tid(2);
    look(32'h10, 0, 0, 0, 0, 0, 0, "R11");
    cmd(FILL, 32'h0, 32'hFFF, 2'b00, 0, 0, 0, 0, "R11");
    look(32'h10, 0, 1, 1, 0, 0, 0, "R11");
    cmd(SET, 32'h10, 32'h20, 2'b01, 0, 0, 0, 0, "R11");
    look(32'h10, 0, 1, 1, 1, 0, 0, "R11");
    look(32'hF, 0, 1, 2, 0, 0, 0, "R11");
    look(32'h21, 0, 1, 3, 0, 0, 0, "R11");
    set_tid(1);
    look(32'h10, 0, 1, 0, 1, 0, 0, "R11");
    look(32'hFFF, 0, 1, 0, 1, 0, 0, "R11");
    clear_all();
  endtask

  task automatic t_overflow();
    set_tid(0);
    cmd(FILL, 32'h0, TOP, 2'b00, 0, 0, 0, 0, "R9");
    set_tid(1);
    for (int i = 1; i < N - 1; i++)
      cmd(FILL, 32'(i * 256), 32'(i * 256 + 255), 2'b11, 0, 0, 0, 0, "R9");
    set_tid(0);
    cmd(SET, 32'h100, 32'h1FF, 2'b10, 0, 0, 0, 1, "R8");
    look(32'h150, 1, 1, 0, 0, 0, 0, "R8");
    look(32'h0, 0, 1, 0, 0, 0, 0, "R8");
    cmd(FILL, 32'h10, 32'h20, 2'b01, 0, 0, 0, 0, "R9");
    cmd(FILL, 32'h30, 32'h40, 2'b01, 0, 0, 0, 1, "R9");
    look(32'h35, 0, 1, 0, 0, 0, 0, "R9");
    look(32'h15, 0, 1, 0, 0, 0, 0, "R6");
    cmd(SET, 32'h0, TOP, 2'b11, 0, 0, 0, 0, "R8");
    look(32'h15, 1, 1, 0, 1, 0, 0, "R8");
    set_tid(1);
    look(32'h150, 0, 1, 1, 1, 0, 0, "R11");
    evict(15, 0, 0, 0, 0, "R7");
    clear_all();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog all-R actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_split();
    t_multi();
    t_prio();
    t_bitmap();
    t_thread();
    t_overflow();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule